// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions towards an Ethernet PHY. Software places a complete, preformatted 32-bit command word in the data register; the block then produces a management clock from the system clock, sends 32 preamble ones followed by the 32 command bits on the serial data line, and, for a read, releases the line and captures the 16 bits the PHY returns. When the transaction ends, a completion flag in the event register is raised and stays up until software clears it by writing a one to it.

The register port is a plain synchronous write strobe with an address and combinational read data. The pad itself is outside the block: it presents a data output, an output enable and a data input. The management clock rate comes from a six-bit speed field, and a zero field freezes the clock so that a written command waits until a nonzero rate is programmed.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the data, event and speed registers read zero, `mdc` is low, `mdio_oe` is low and `mdio_out` is high.
- R2: A transaction is 64 MDC periods: 32 ones, then command bits 31 down to 0. Each bit is presented for one whole MDC period starting after an MDC falling edge, so it is stable at the following rising edge; the transaction ends at the 64th falling edge.
- R3: The speed register (address 2) holds the divider S in bits 6:1; its other bits read zero. While a transaction runs, each MDC high phase and low phase lasts S system clock cycles, and MDC toggles only while a transaction runs.
- R4: A command whose bits 29:28 are 2'b10 is a read: `mdio_oe` is low for the last 18 bit periods (frame bits 17:0), the line is sampled at the last 16 MDC rising edges, first sample into bit 15, and the result replaces bits 15:0 of the data register (address 0) while bits 31:16 keep the command.
- R5: Any other command is a write: `mdio_oe` is high for all 64 bit periods and the data register keeps the command word.
- R6: The completion flag is bit 23 of the event register (address 1). It is set when a transaction ends, a write with bit 23 set clears it, and a write with bit 23 clear leaves it set.
- R7: With S equal to zero MDC makes no edge and a written command stays pending; the transaction runs once S becomes nonzero.
- R8: A write to the data register while a transaction is in progress is ignored: neither the frame on the line nor the register contents change.
- R9: Between transactions `mdio_oe` and `mdc` are low and `mdio_out` is high; address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 event, 2 speed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data towards the pad |
| mdio_oe | output | 1 | Pad drive enable |
| mdio_in | input | 1 | Serial data from the pad |

## Verification
The assertions take for granted that software leaves the speed field alone while a transaction is in flight, since a rate change mid-frame would alter the phase lengths they and the bench reason about; only the zero-speed pending case changes the field while a command waits, before any MDC edge. They also assume `mdio_in` is steady around MDC rising edges. The bench programs the speed only between transactions, draws random PHY addresses, register numbers, data, opcodes and speeds from a fixed seed, and, acting as the PHY, changes `mdio_in` one nanosecond after each MDC rising edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int CMD_W     = 32;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int RD_W      = 16;
    localparam int TA_LEN    = 2;
    localparam int REL_POS   = FRAME_LEN - RD_W - TA_LEN;
    localparam int CAP_POS   = FRAME_LEN - RD_W;
    localparam int DIV_W     = 6;
    localparam int DIV_LSB   = 1;
    localparam int EVT_BIT   = 23;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] A_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] A_EVT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_SPEED = 2'd2;
    localparam logic [1:0]        OP_RD   = 2'b10;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    typedef struct packed {
        logic             busy;
        logic             rd;
        logic [POS_W-1:0] pos;
        logic [CMD_W-1:0] cmd;
        logic [RD_W-1:0]  shf;
        logic             done;
    } eng_st_t;

    typedef struct packed {
        logic [CMD_W-1:0] data;
        logic [DIV_W-1:0] div;
        logic             evt;
    } reg_st_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div
    import mdio_mgmt_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         mdc,
    output logic         rise,
    output logic         fall
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         mdc;
    } st_t;

    st_t q, d;

    always_comb begin
        d    = q;
        rise = 1'b0;
        fall = 1'b0;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (div != '0) begin
            if (q.cnt == div - 1'b1) begin
                d.cnt = '0;
                d.mdc = ~q.mdc;
                rise  = ~q.mdc;
                fall  = q.mdc;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             rise,
    input  logic             fall,
    input  logic             mdio_in,
    output logic             busy,
    output logic             done,
    output logic             rd_done,
    output logic [RD_W-1:0]  rd_data,
    output logic             mdio_out,
    output logic             mdio_oe
);
    eng_st_t q, d;
    logic    cur_bit;
    logic    released;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.pos  = '0;
                d.cmd  = cmd;
                d.rd   = (cmd[29:28] == OP_RD);
            end
        end else begin
            if (rise && q.rd && q.pos >= POS_W'(CAP_POS))
                d.shf = {q.shf[RD_W-2:0], mdio_in};
            if (fall) begin
                if (q.pos == POS_W'(FRAME_LEN - 1)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (q.pos[POS_W-1]) cur_bit = q.cmd[~q.pos[POS_W-2:0]];
        else                cur_bit = 1'b1;
        released = q.rd && (q.pos >= POS_W'(REL_POS));
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign rd_done  = q.done && q.rd;
    assign rd_data  = q.shf;
    assign mdio_out = q.busy ? cur_bit : 1'b1;
    assign mdio_oe  = q.busy && !released;
endmodule

// File: rtl/mdio_reg_port.sv
module mdio_reg_port
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              rd_done,
    input  logic [RD_W-1:0]   rd_data,
    output logic              start,
    output logic [CMD_W-1:0]  cmd,
    output logic [DIV_W-1:0]  div,
    output logic              evt,
    output logic [CMD_W-1:0]  rdata
);
    reg_st_t q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        if (wen && addr == A_DATA && !busy) begin
            d.data = wdata;
            start  = 1'b1;
        end else if (rd_done) begin
            d.data[RD_W-1:0] = rd_data;
        end
        if (wen && addr == A_SPEED)
            d.div = wdata[DIV_LSB +: DIV_W];
        if (done)
            d.evt = 1'b1;
        else if (wen && addr == A_EVT && wdata[EVT_BIT])
            d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA:  rdata = q.data;
            A_EVT:   rdata[EVT_BIT] = q.evt;
            A_SPEED: rdata[DIV_LSB +: DIV_W] = q.div;
            default: rdata = '0;
        endcase
    end

    assign cmd = wdata;
    assign div = q.div;
    assign evt = q.evt;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [CMD_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic             eng_busy, eng_done, eng_rd_done;
    logic [RD_W-1:0]  eng_rd_data;
    logic             go;
    logic [CMD_W-1:0] go_cmd;
    logic [DIV_W-1:0] div_val;
    logic             evt_flag;
    logic             mdc_rise, mdc_fall;

    mdio_reg_port u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
        .wdata(reg_wdata), .busy(eng_busy), .done(eng_done),
        .rd_done(eng_rd_done), .rd_data(eng_rd_data), .start(go),
        .cmd(go_cmd), .div(div_val), .evt(evt_flag), .rdata(reg_rdata)
    );

    mdio_mdc_div #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div_val),
        .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(go), .cmd(go_cmd),
        .rise(mdc_rise), .fall(mdc_fall), .mdio_in(mdio_in),
        .busy(eng_busy), .done(eng_done), .rd_done(eng_rd_done),
        .rd_data(eng_rd_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              evt,
    input logic [DIV_W-1:0]  div,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              mdio_out,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CMD_W-1:0]  reg_rdata
);
    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && div == '0) |=> $stable(mdc));

    a_r6_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    a_r6_event_raised: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc && mdio_out));

    a_r3_mdc_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != $past(mdc)) |-> $past(busy));

    a_r3_speed_field_only: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SPEED) |-> (reg_rdata[0] == 1'b0 && reg_rdata[CMD_W-1:DIV_LSB+DIV_W] == '0));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .done(eng_done),
    .evt(evt_flag), .div(div_val), .mdc(mdc), .mdio_oe(mdio_oe),
    .mdio_out(mdio_out), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    logic [63:0] obs_out, obs_oe;
    int          rcnt;
    logic [15:0] phy_val;
    longint      t_rise;
    int          hi_len, lo_len;
    longint      t_fall;

    always #4 clk = ~clk;

    mdio_mgmt_master u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY model: observes at rising MDC, drives read data just after it
    always @(posedge mdc) begin
        if (rcnt < 64) begin
            obs_out[63-rcnt] = mdio_out;
            obs_oe[63-rcnt]  = mdio_oe;
        end
        if (rcnt > 0) lo_len = int'(($time - t_fall) / 8);
        t_rise = $time;
        rcnt = rcnt + 1;
        #1;
        if (rcnt >= 48 && rcnt < 64) mdio_in = phy_val[63-rcnt];
        else                         mdio_in = 1'b1;
    end

    always @(negedge mdc) begin
        hi_len = int'(($time - t_rise) / 8);
        t_fall = $time;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] mk_cmd(input bit is_rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] val);
        logic [31:0] c;
        c = is_rd ? 32'h6002_0000 : 32'h5002_0000;
        c = c | ({27'd0, phy} << 23) | ({27'd0, rg} << 18);
        if (!is_rd) c = c | {16'd0, val};
        return c;
    endfunction

    task automatic arm(input logic [15:0] pv);
        rcnt = 0; obs_out = '0; obs_oe = '0; phy_val = pv; hi_len = 0; lo_len = 0;
    endtask

    task automatic wait_evt(output bit seen);
        logic [31:0] v;
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            rd(2'd1, v);
            seen = v[23];
        end
    endtask

    // checks a finished transaction against the expected frame
    task automatic verify(input logic [31:0] cmd, input int spd, input logic [15:0] pv);
        bit          seen;
        bit          is_rd;
        logic [63:0] exp_oe, exp_fr;
        logic [31:0] v, exp_data;
        wait_evt(seen);
        chk(seen, "R6 completion flag", seen, 1);
        is_rd  = (cmd[29:28] == 2'b10);
        exp_fr = {32'hFFFF_FFFF, cmd};
        exp_oe = is_rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        chk(rcnt == 64, "R2 rising edge count", rcnt, 64);
        chk(obs_oe == exp_oe, is_rd ? "R4 oe pattern" : "R5 oe pattern", obs_oe, exp_oe);
        chk((obs_out & exp_oe) == (exp_fr & exp_oe), "R2 frame bits", obs_out & exp_oe, exp_fr & exp_oe);
        chk(hi_len == spd && lo_len == spd, "R3 mdc phase length", {hi_len, lo_len}, {spd, spd});
        exp_data = is_rd ? {cmd[31:16], pv} : cmd;
        rd(2'd0, v);
        chk(v == exp_data, is_rd ? "R4 read data" : "R5 data kept", v, exp_data);
        chk(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_out == 1'b1, "R9 idle pins",
            {mdc, mdio_oe, mdio_out}, 3'b001);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, v);
        chk(v[23] == 1'b1, "R6 zero write keeps flag", v[23], 1);
        wr(2'd1, 32'h0080_0000);
        rd(2'd1, v);
        chk(v == 32'd0, "R6 clear by one", v, 0);
    endtask

    task automatic txn(input logic [31:0] cmd, input int spd, input logic [15:0] pv);
        wr(2'd2, spd << 1);
        arm(pv);
        wr(2'd0, cmd);
        verify(cmd, spd, pv);
    endtask

    initial begin
        logic [31:0] v, c1, c2;
        int          seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        arm(16'h0);

        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 data reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 event reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 speed reset", v, 0);
        chk(mdc == 0 && mdio_oe == 0 && mdio_out == 1, "R1 pins reset", {mdc, mdio_oe, mdio_out}, 3'b001);
        rd(2'd3, v); chk(v == 0, "R9 unused address", v, 0);

        // R3 speed register field
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk(v == 32'h7E, "R3 speed readback", v, 32'h7E);

        // R7 speed zero holds a command pending
        wr(2'd2, 32'h0);
        arm(16'hA5C3);
        c1 = mk_cmd(1'b1, 5'd3, 5'd2, 16'h0);
        wr(2'd0, c1);
        repeat (60) @(negedge clk);
        chk(rcnt == 0 && mdc == 0, "R7 no mdc edges", rcnt, 0);
        rd(2'd1, v); chk(v == 0, "R7 still pending", v, 0);
        wr(2'd2, 32'd2 << 1);
        verify(c1, 2, 16'hA5C3);

        // directed read and write at fastest speed
        txn(mk_cmd(1'b1, 5'd31, 5'd31, 16'h0), 1, 16'hFFFF);
        txn(mk_cmd(1'b0, 5'd0, 5'd0, 16'h0000), 1, 16'h0);
        txn(32'hFFFF_FFFF, 2, 16'h1234);  // R5 opcode 2'b11 runs as write

        // R8 write during a running transaction is ignored
        c1 = mk_cmd(1'b0, 5'd9, 5'd4, 16'hBEEF);
        c2 = mk_cmd(1'b1, 5'd1, 5'd1, 16'h0);
        wr(2'd2, 32'd3 << 1);
        arm(16'h0);
        wr(2'd0, c1);
        repeat (30) @(negedge clk);
        wr(2'd0, c2);
        rd(2'd0, v); chk(v == c1, "R8 data unchanged while busy", v, c1);
        verify(c1, 3, 16'h0);

        // constrained random transactions
        for (int i = 0; i < 12; i++) begin
            bit          r;
            logic [15:0] pv, dv;
            int          s;
            r  = $urandom_range(1, 0) == 1;
            pv = 16'($urandom);
            dv = 16'($urandom);
            s  = $urandom_range(5, 1);
            txn(mk_cmd(r, 5'($urandom), 5'($urandom), dv), s, pv);
        end

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule